// File: doc/BRIEF.md
# Next-Fetch-Address and Branch Resolution Unit

This unit owns the fetch address of a 32-bit processor whose instructions are word-aligned and whose control transfers carry one architectural delay slot. Each cycle it inspects the instruction word fetched from the current fetch address, together with the two register operands read for it. When the word is a jump, a register jump or a conditional branch whose condition holds, the unit fetches the delay-slot word at the following address first, and only then moves to the target. When no transfer is taken, it steps forward by one word.

The unit also issues the return-address write for the linking forms. The write goes to register 31, or to the rd field of the register-indirect call. The return address is the transfer's own address plus 8, which skips the delay slot. The branch-and-link forms issue this write whether or not the branch is taken.

Control is a two-state machine. ST_SEQ is sequential fetch. In ST_SEQ a taken transfer (transition SEQ_TO_SLOT) latches the target and fetches the delay slot. ST_SLOT is delay-slot fetch. In ST_SLOT the next valid cycle (transition SLOT_TO_SEQ) loads the latched target. A cycle with `instr_valid` low stalls the unit in either state (transition HOLD).

Top module: `npc_branch_unit`

## Requirements
- R1: While reset is asserted, and just after it is released, `fetch_pc` equals the parameter RESET_PC (default 0xBFC00000) and `in_delay_slot` is 0. Reset taken in the middle of a delay slot abandons the pending target.
- R2: In ST_SEQ, a valid word that is not a taken transfer advances `fetch_pc` by 4 at the next clock edge. This includes a not-taken branch and a non-control word such as 0x00000000.
- R3: Opcode 000010 (jump) and opcode 000011 (jump and link) give the target {fetch_pc[31:28], instr[25:0], 2'b00}.
- R4: Opcode 000100 is taken when the rs and rt operands are equal, and opcode 000101 is taken when they differ. The target is fetch_pc + 4 + (sign-extended instr[15:0] shifted left by 2). Encoding 0x10000000 plus an offset, with both operands zero, is always taken.
- R5: Opcode 000001 chooses its test by instr[20:16]. Codes 00001 and 10001 are taken when rs bit 31 is 0. Codes 00000 and 10000 are taken when rs bit 31 is 1. The target is formed as in R4.
- R6: Opcode 000000 with funct 001000 (register jump) or funct 001001 (register call) redirects to the full 32-bit rs operand.
- R7: After a taken transfer at address P, `fetch_pc` becomes P+4 with `in_delay_slot` 1. At the next valid cycle it becomes the target.
- R8: Opcode 000011 requests a write to register 31, and funct 001001 requests a write to register instr[15:11]. The write data is fetch_pc + 8, and it appears in the same cycle as the word on `link_we`, `link_reg` and `link_data`.
- R9: Codes 10001 and 10000 under opcode 000001 request a register-31 link write even when their condition is false.
- R10: A word presented while `in_delay_slot` is 1 is not decoded as a transfer. `xfer_taken` and `link_we` stay 0, and the fetch proceeds to the latched target.
- R11: While `instr_valid` is 0, `fetch_pc` and the state hold, and `xfer_taken` and `link_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | The word at `fetch_pc` and its operands are present this cycle |
| instr | input | 32 | Instruction word fetched from `fetch_pc` |
| rs_val | input | 32 | Value of register rs |
| rt_val | input | 32 | Value of register rt |
| fetch_pc | output | 32 | Current fetch address |
| xfer_taken | output | 1 | The current word is a taken transfer |
| redirect_target | output | 32 | Target of the taken transfer (0 otherwise) |
| in_delay_slot | output | 1 | The current word sits in a delay slot |
| link_we | output | 1 | Return-address write request |
| link_reg | output | 5 | Register index for the return address |
| link_data | output | 32 | Return address (fetch_pc + 8) |

## Verification
The decode results `xfer_taken`, `redirect_target` and the three link outputs are combinational, so they are due in the cycle the word is presented. The bench samples them two time units after driving the inputs, before the next rising edge. `fetch_pc` is registered. It is checked one time unit after the first edge for the delay-slot address or the sequential step, and after the second valid edge for the target. Stalls push that second check back by one edge for each cycle in which `instr_valid` is low.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int OP_W   = 6;
    localparam int IMM_W  = 16;
    localparam int IDX_W  = 26;
    localparam int SEG_W  = XLEN - IDX_W - 2;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
    localparam logic [OP_W-1:0] OP_REGIMM  = 6'b000001;
    localparam logic [OP_W-1:0] OP_JUMP    = 6'b000010;
    localparam logic [OP_W-1:0] OP_CALL    = 6'b000011;
    localparam logic [OP_W-1:0] OP_BREQ    = 6'b000100;
    localparam logic [OP_W-1:0] OP_BRNE    = 6'b000101;

    localparam logic [5:0] FN_JREG  = 6'b001000;
    localparam logic [5:0] FN_JCALL = 6'b001001;

    localparam logic [REG_AW-1:0] RI_GEZ     = 5'b00001;
    localparam logic [REG_AW-1:0] RI_LTZ     = 5'b00000;
    localparam logic [REG_AW-1:0] RI_GEZ_LNK = 5'b10001;
    localparam logic [REG_AW-1:0] RI_LTZ_LNK = 5'b10000;

    typedef enum logic [2:0] {
        CT_NONE,
        CT_JABS,
        CT_JREG,
        CT_BEQ,
        CT_BNE,
        CT_BGEZ,
        CT_BLTZ
    } ctl_kind_e;

    typedef enum logic {
        ST_SEQ,
        ST_SLOT
    } fetch_state_e;

    typedef struct packed {
        ctl_kind_e         kind;
        logic              link;
        logic [REG_AW-1:0] link_reg;
    } ctl_dec_s;
endpackage

// File: rtl/npc_decoder.sv
module npc_decoder
    import npc_pkg::*;
#(
    parameter logic [REG_AW-1:0] LINK_REG = 5'd31
) (
    input  logic [XLEN-1:0] instr,
    output ctl_dec_s        dec
);
    logic [OP_W-1:0]   opcode;
    logic [REG_AW-1:0] rt_f;
    logic [REG_AW-1:0] rd_f;
    logic [5:0]        funct;

    assign opcode = instr[31:26];
    assign rt_f   = instr[20:16];
    assign rd_f   = instr[15:11];
    assign funct  = instr[5:0];

    always_comb begin
        dec.kind     = CT_NONE;
        dec.link     = 1'b0;
        dec.link_reg = LINK_REG;
        case (opcode)
            OP_SPECIAL: begin
                if (funct == FN_JREG) begin
                    dec.kind = CT_JREG;
                end else if (funct == FN_JCALL) begin
                    dec.kind     = CT_JREG;
                    dec.link     = 1'b1;
                    dec.link_reg = rd_f;
                end
            end
            OP_REGIMM: begin
                case (rt_f)
                    RI_GEZ:     dec.kind = CT_BGEZ;
                    RI_LTZ:     dec.kind = CT_BLTZ;
                    RI_GEZ_LNK: begin
                        dec.kind = CT_BGEZ;
                        dec.link = 1'b1;
                    end
                    RI_LTZ_LNK: begin
                        dec.kind = CT_BLTZ;
                        dec.link = 1'b1;
                    end
                    default:    dec.kind = CT_NONE;
                endcase
            end
            OP_JUMP:  dec.kind = CT_JABS;
            OP_CALL: begin
                dec.kind = CT_JABS;
                dec.link = 1'b1;
            end
            OP_BREQ:  dec.kind = CT_BEQ;
            OP_BRNE:  dec.kind = CT_BNE;
            default:  dec.kind = CT_NONE;
        endcase
    end
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
(
    input  ctl_kind_e       kind,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            taken
);
    logic ops_equal;
    logic rs_neg;

    assign ops_equal = (rs_val == rt_val);
    assign rs_neg    = rs_val[XLEN-1];

    always_comb begin
        unique case (kind)
            CT_JABS, CT_JREG: taken = 1'b1;
            CT_BEQ:           taken = ops_equal;
            CT_BNE:           taken = !ops_equal;
            CT_BGEZ:          taken = !rs_neg;
            CT_BLTZ:          taken = rs_neg;
            default:          taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
(
    input  ctl_kind_e       kind,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs_val,
    output logic [XLEN-1:0] target
);
    localparam int EXT_W = XLEN - IMM_W - 2;

    logic [XLEN-1:0] slot_pc;
    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] seg_tgt;

    assign slot_pc = pc + XLEN'(4);
    assign disp    = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0], 2'b00};
    assign rel_tgt = slot_pc + disp;
    assign seg_tgt = {pc[XLEN-1 -: SEG_W], instr[IDX_W-1:0], 2'b00};

    always_comb begin
        unique case (kind)
            CT_JABS:                            target = seg_tgt;
            CT_JREG:                            target = rs_val;
            CT_BEQ, CT_BNE, CT_BGEZ, CT_BLTZ:   target = rel_tgt;
            default:                            target = slot_pc;
        endcase
    end
endmodule

// File: rtl/npc_branch_unit.sv
module npc_branch_unit
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0]   RESET_PC = 32'hBFC0_0000,
    parameter logic [REG_AW-1:0] LINK_REG = 5'd31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    output logic [XLEN-1:0]   fetch_pc,
    output logic              xfer_taken,
    output logic [XLEN-1:0]   redirect_target,
    output logic              in_delay_slot,
    output logic              link_we,
    output logic [REG_AW-1:0] link_reg,
    output logic [XLEN-1:0]   link_data
);
    fetch_state_e    state_q, state_d;
    logic [XLEN-1:0] pc_q, pc_d;
    logic [XLEN-1:0] pend_q, pend_d;

    ctl_dec_s        dec;
    logic            cond_ok;
    logic [XLEN-1:0] tgt;
    logic            decode_en;

    npc_decoder #(.LINK_REG(LINK_REG)) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    npc_cond_eval u_cond (
        .kind   (dec.kind),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .taken  (cond_ok)
    );

    npc_target_gen u_tgt (
        .kind   (dec.kind),
        .pc     (pc_q),
        .instr  (instr),
        .rs_val (rs_val),
        .target (tgt)
    );

    // only a valid word outside a delay slot is decoded as a transfer
    assign decode_en = instr_valid && (state_q == ST_SEQ);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
            pc_q    <= RESET_PC;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            pend_q  <= pend_d;
        end
    end

    // next-state: SEQ_TO_SLOT, SLOT_TO_SEQ, HOLD
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_SEQ: begin
                if (instr_valid) begin
                    pc_d = pc_q + XLEN'(4);
                    if (cond_ok) begin
                        state_d = ST_SLOT;
                        pend_d  = tgt;
                    end
                end
            end
            ST_SLOT: begin
                if (instr_valid) begin
                    pc_d    = pend_q;
                    state_d = ST_SEQ;
                end
            end
            default: state_d = ST_SEQ;
        endcase
    end

    // outputs
    always_comb begin
        fetch_pc        = pc_q;
        in_delay_slot   = (state_q == ST_SLOT);
        xfer_taken      = decode_en && cond_ok;
        redirect_target = (decode_en && cond_ok) ? tgt : '0;
        link_we         = decode_en && dec.link;
        link_reg        = dec.link_reg;
        link_data       = pc_q + XLEN'(8);
    end
endmodule

// File: rtl/npc_branch_unit_chk.sv
module npc_branch_unit_chk
    import npc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [XLEN-1:0]   fetch_pc,
    input logic              xfer_taken,
    input logic [XLEN-1:0]   redirect_target,
    input logic              in_delay_slot,
    input logic              link_we
);
    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && !in_delay_slot && !xfer_taken |=> fetch_pc == $past(fetch_pc) + 32'd4); // R2

    AST_SLOT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && xfer_taken |=> in_delay_slot && fetch_pc == $past(fetch_pc) + 32'd4); // R7

    AST_TARGET_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && xfer_taken) ##1 instr_valid |=> fetch_pc == $past(redirect_target, 2)); // R7

    AST_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_delay_slot |-> !xfer_taken && !link_we); // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(fetch_pc) && $stable(in_delay_slot)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !xfer_taken && !link_we); // R11
endmodule

bind npc_branch_unit npc_branch_unit_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .instr_valid     (instr_valid),
    .fetch_pc        (fetch_pc),
    .xfer_taken      (xfer_taken),
    .redirect_target (redirect_target),
    .in_delay_slot   (in_delay_slot),
    .link_we         (link_we)
);

// File: tb/npc_branch_unit_bench.sv
module npc_branch_unit_bench;
    localparam logic [31:0] RST_PC = 32'hBFC0_0000;
    localparam logic [31:0] NOP    = 32'h0000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [31:0] instr, rs_val, rt_val;
    logic [31:0] fetch_pc, redirect_target, link_data;
    logic        xfer_taken, in_delay_slot, link_we;
    logic [4:0]  link_reg;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    npc_branch_unit u_npc_branch_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .fetch_pc(fetch_pc),
        .xfer_taken(xfer_taken), .redirect_target(redirect_target),
        .in_delay_slot(in_delay_slot), .link_we(link_we),
        .link_reg(link_reg), .link_data(link_data)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [31:0] pc;
        logic [31:0] iw;
        logic [31:0] rsv;
        logic [31:0] rtv;
        logic        tk;
        logic [31:0] tgt;
        logic        lwe;
        logic [4:0]  lreg;
    } vec_t;

    localparam vec_t VEC [15] = '{
        '{4'd3,  32'h3000_0010, 32'h0800_0100, 32'h0,          32'h0, 1'b1, 32'h3000_0400, 1'b0, 5'd0 },  // R3 jump
        '{4'd3,  32'h7000_0020, 32'h0FFF_FFFF, 32'h0,          32'h0, 1'b1, 32'h7FFF_FFFC, 1'b1, 5'd31},  // R3 R8 call
        '{4'd4,  32'h0000_1000, 32'h1000_0003, 32'h0,          32'h0, 1'b1, 32'h0000_1010, 1'b0, 5'd0 },  // R4 r0==r0
        '{4'd4,  32'h0000_1000, 32'h1022_0003, 32'h5,          32'h6, 1'b0, 32'h0,         1'b0, 5'd0 },  // R4 beq ne
        '{4'd4,  32'h0000_2000, 32'h1422_FFFF, 32'h5,          32'h6, 1'b1, 32'h0000_2000, 1'b0, 5'd0 },  // R4 bne back
        '{4'd4,  32'h0000_2000, 32'h1422_FFFF, 32'h7,          32'h7, 1'b0, 32'h0,         1'b0, 5'd0 },  // R4 bne eq
        '{4'd5,  32'h0000_4000, 32'h0461_0010, 32'h0,          32'h0, 1'b1, 32'h0000_4044, 1'b0, 5'd0 },  // R5 gez 0
        '{4'd5,  32'h0000_4000, 32'h0460_0010, 32'h8000_0000,  32'h0, 1'b1, 32'h0000_4044, 1'b0, 5'd0 },  // R5 ltz
        '{4'd5,  32'h0000_4000, 32'h0460_0010, 32'h1,          32'h0, 1'b0, 32'h0,         1'b0, 5'd0 },  // R5 ltz no
        '{4'd9,  32'h0000_5000, 32'h0471_0010, 32'hFFFF_FFFF,  32'h0, 1'b0, 32'h0,         1'b1, 5'd31},  // R9 gezal no
        '{4'd9,  32'h0000_5000, 32'h0470_0010, 32'h8000_0000,  32'h0, 1'b1, 32'h0000_5044, 1'b1, 5'd31},  // R9 ltzal
        '{4'd6,  32'h0000_6000, 32'h0080_0008, 32'hDEAD_BEE0,  32'h0, 1'b1, 32'hDEAD_BEE0, 1'b0, 5'd0 },  // R6 jr
        '{4'd6,  32'h0000_6000, 32'h0080_4809, 32'h1234_5678,  32'h0, 1'b1, 32'h1234_5678, 1'b1, 5'd9 },  // R6 R8 jalr
        '{4'd4,  32'h0002_0000, 32'h1000_8000, 32'h0,          32'h0, 1'b1, 32'h0000_0004, 1'b0, 5'd0 },  // R4 far back
        '{4'd2,  32'h0000_7000, 32'h0000_0000, 32'h0,          32'h0, 1'b0, 32'h0,         1'b0, 5'd0 }   // R2 nop
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        instr_valid = v;
        instr       = w;
        rs_val      = a;
        rt_val      = b;
        #2;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // redirect through a register jump and its delay slot
    task automatic go_to(input logic [31:0] dst);
        drive(1'b1, 32'h0080_0008, dst, 32'h0);
        step();
        drive(1'b1, NOP, 32'h0, 32'h0);
        step();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, NOP, 32'h0, 32'h0);
        step();
        step();
        chk("R1 reset pc", fetch_pc, RST_PC);
        chk("R1 reset slot", {31'b0, in_delay_slot}, 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 after release pc", fetch_pc, RST_PC);
        chk("R11 idle no transfer", {30'b0, xfer_taken, link_we}, 32'h0);

        for (int i = 0; i < 15; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
            go_to(VEC[i].pc);
            chk({tag, " R6 setup"}, fetch_pc, VEC[i].pc);
            drive(1'b1, VEC[i].iw, VEC[i].rsv, VEC[i].rtv);
            chk({tag, " taken"}, {31'b0, xfer_taken}, {31'b0, VEC[i].tk});
            if (VEC[i].tk) chk({tag, " target"}, redirect_target, VEC[i].tgt);
            chk({tag, " R8 link_we"}, {31'b0, link_we}, {31'b0, VEC[i].lwe});
            if (VEC[i].lwe) begin
                chk({tag, " R8 link_reg"}, {27'b0, link_reg}, {27'b0, VEC[i].lreg});
                chk({tag, " R8 link_data"}, link_data, VEC[i].pc + 32'd8);
            end
            step();
            chk({tag, " R7 slot fetch"}, fetch_pc, VEC[i].pc + 32'd4);
            drive(1'b1, NOP, 32'h0, 32'h0);
            step();
            chk({tag, " R7 next fetch"}, fetch_pc, VEC[i].tk ? VEC[i].tgt : VEC[i].pc + 32'd8);
        end

        // R10: transfer word in a delay slot is ignored
        go_to(32'h0000_0100);
        drive(1'b1, 32'h0800_0080, 32'h0, 32'h0);
        step();
        drive(1'b1, 32'h0FFF_FFFF, 32'h0, 32'h0);
        chk("R10 slot flag", {31'b0, in_delay_slot}, 32'h1);
        chk("R10 slot quiet", {30'b0, xfer_taken, link_we}, 32'h0);
        step();
        chk("R10 target reached", fetch_pc, 32'h0000_0200);

        // R11: stall in sequential state and in delay slot
        drive(1'b0, 32'h0FFF_FFFF, 32'h0, 32'h0);
        chk("R11 stall quiet", {30'b0, xfer_taken, link_we}, 32'h0);
        step();
        step();
        chk("R11 stall hold", fetch_pc, 32'h0000_0200);
        drive(1'b1, 32'h0800_0080, 32'h0, 32'h0);
        step();
        drive(1'b0, NOP, 32'h0, 32'h0);
        step();
        chk("R11 slot hold pc", fetch_pc, 32'h0000_0204);
        chk("R11 slot hold flag", {31'b0, in_delay_slot}, 32'h1);
        drive(1'b1, NOP, 32'h0, 32'h0);
        step();
        chk("R11 resume target", fetch_pc, 32'h0000_0200);

        // R1: reset in the middle of a delay slot
        drive(1'b1, 32'h0800_0080, 32'h0, 32'h0);
        step();
        rst_n = 1'b0;
        drive(1'b0, NOP, 32'h0, 32'h0);
        step();
        rst_n = 1'b1;
        chk("R1 mid reset pc", fetch_pc, RST_PC);
        chk("R1 mid reset slot", {31'b0, in_delay_slot}, 32'h0);
        drive(1'b1, NOP, 32'h0, 32'h0);
        step();
        chk("R2 step after reset", fetch_pc, RST_PC + 32'd4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule